// File: doc/BRIEF.md
# Long Multiply-Accumulate Execution Unit

This unit executes the 32-bit long-multiply instruction group. From one instruction word it works out which multiply to run, picks the operands and computes a 64-bit result. The group covers these forms:

- signed and unsigned full-word multiply;
- multiply with a 64-bit accumulate;
- a single signed halfword product, with a chosen half of each source, added to the accumulator;
- two signed halfword products that are summed or differenced, with an optional swap of the second source's halves;
- an unsigned multiply that adds both destination words as two separate addends.

The surrounding core reads four source values from its register file and presents them on ports with the instruction and a valid strobe. These are the two multiplicands and the current contents of the low and high destination registers. One clock later the unit returns the low and high result words. It also returns the two destination indices to write them to, with a write enable for each.

Encodings that match none of the group's patterns raise an undefined flag. Recognised encodings that name register 15 in any field, or that give the same register for both destinations, raise an unpredictable flag. Neither flagged case enables a write.

Top module: `lmac_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both write enables and the undefined and unpredictable flags are 0.
- R2: Outputs are registered and appear on the first rising edge after a cycle with `in_valid` high. After a cycle with `in_valid` low, the write enables and both flags are 0 and the result words hold their previous values.
- R3: With bits [31:24] = 0xFB and bits [7:4] = 0000, bits [23:20] = 1000 give the signed 32x32 multiply and 1010 give the unsigned one. The full 64-bit product is kept, with no accumulate.
- R4: With bits [7:4] = 0000, bits [23:20] = 1100 give the signed multiply-accumulate and 1110 give the unsigned one. Each returns product + {RdHi,RdLo} modulo 2^64.
- R5: With bits [23:20] = 1100 and bits [7:6] = 10, the halfword form applies. Bit 5 picks the upper (1) or lower (0) half of Rn and bit 4 picks the half of Rm the same way. The signed 16x16 product is sign-extended and added to {RdHi,RdLo}.
- R6: With bits [7:5] = 110, bits [23:20] = 1100 give the dual-add form and 1101 give the dual-subtract form. The form computes lowRn*lowRm ± highRn*highRm + {RdHi,RdLo}, with signed halves, and the high product is subtracted for 1101. When bit 4 is 1, the halves of Rm are exchanged first.
- R7: With bits [23:20] = 1110 and bits [7:4] = 0110, the result is the unsigned Rn*Rm + RdHi + RdLo. It never exceeds 64 bits.
- R8: A recognised encoding is flagged unpredictable, and enables no write, when any of Rn [19:16], RdLo [15:12], RdHi [11:8] or Rm [3:0] is 15, or when RdLo equals RdHi.
- R9: Any word that matches no pattern of R3 to R7 raises the undefined flag and enables no write. The unpredictable flag stays 0 for such a word.
- R10: For a legal instruction both write enables are 1. The low result word goes to the index in bits [15:12] and the high result word to the index in bits [11:8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| insn | input | 32 | Instruction word |
| rn_val | input | XLEN | First multiplicand |
| rm_val | input | XLEN | Second multiplicand |
| acc_lo_val | input | XLEN | Current value of the low destination register |
| acc_hi_val | input | XLEN | Current value of the high destination register |
| res_lo_o | output | XLEN | Low result word |
| res_hi_o | output | XLEN | High result word |
| lo_idx_o | output | IDX_W | Register index for the low word |
| hi_idx_o | output | IDX_W | Register index for the high word |
| lo_we_o | output | 1 | Write enable for the low word |
| hi_we_o | output | 1 | Write enable for the high word |
| undef_o | output | 1 | Undefined encoding seen |
| unpred_o | output | 1 | Unpredictable register use seen |

## Verification
The bench builds the unit with its defaults: a 32-bit word, 4-bit register indices and register 15 as the forbidden index. These match the encoding's field widths, so every real decode path and every hazard case can be reached. With a 32-bit word, a 64-bit reference model can represent every result exactly. The operands that stress that model are 0x80000000, the 0x8000 halfword and all-ones words, which reach the largest signed product, the subtract borrow and the largest unsigned double-accumulate sum.

// File: rtl/lmac_pkg.sv
package lmac_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_MULL,
      OP_MLAL,
      OP_HALF,
      OP_DUAL,
      OP_UMAAL
   } lmac_op_e;

   typedef struct packed {
      lmac_op_e op;
      logic     sgn;     // operands sign-extended
      logic     sub;     // dual form subtracts the high product
      logic     n_sel;   // halfword form: upper half of Rn
      logic     m_sel;   // upper half of Rm / swap for dual
   } lmac_ctl_t;

endpackage

// File: rtl/lmac_decode.sv
module lmac_decode
   import lmac_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int PC_IDX = 15
) (
   input  logic [31:0]      insn,
   output lmac_ctl_t        ctl,
   output logic             undef,
   output logic             unpred,
   output logic [IDX_W-1:0] lo_idx,
   output logic [IDX_W-1:0] hi_idx
);

   localparam logic [7:0]       GROUP_TAG = 8'hFB;
   localparam logic [IDX_W-1:0] PC_CODE   = IDX_W'(PC_IDX);

   logic [3:0]       sel;
   logic [3:0]       fn;
   logic [IDX_W-1:0] n_idx, m_idx;

   assign sel    = insn[23:20];
   assign fn     = insn[7:4];
   assign n_idx  = IDX_W'(insn[19:16]);
   assign lo_idx = IDX_W'(insn[15:12]);
   assign hi_idx = IDX_W'(insn[11:8]);
   assign m_idx  = IDX_W'(insn[3:0]);

   always_comb begin
      ctl    = '0;
      ctl.op = OP_NONE;
      if (insn[31:24] == GROUP_TAG) begin
         case (sel)
            4'h8: if (fn == 4'b0000) begin ctl.op = OP_MULL; ctl.sgn = 1'b1; end
            4'hA: if (fn == 4'b0000) ctl.op = OP_MULL;
            4'hC: begin
               if (fn == 4'b0000) begin
                  ctl.op  = OP_MLAL;
                  ctl.sgn = 1'b1;
               end else if (fn[3:2] == 2'b10) begin
                  ctl.op    = OP_HALF;
                  ctl.n_sel = fn[1];
                  ctl.m_sel = fn[0];
               end else if (fn[3:1] == 3'b110) begin
                  ctl.op    = OP_DUAL;
                  ctl.m_sel = fn[0];
               end
            end
            4'hD: if (fn[3:1] == 3'b110) begin
               ctl.op    = OP_DUAL;
               ctl.sub   = 1'b1;
               ctl.m_sel = fn[0];
            end
            4'hE: begin
               if (fn == 4'b0000)      ctl.op = OP_MLAL;
               else if (fn == 4'b0110) ctl.op = OP_UMAAL;
            end
            default: ;
         endcase
      end
   end

   assign undef  = (ctl.op == OP_NONE);
   assign unpred = !undef && ((n_idx == PC_CODE) || (m_idx == PC_CODE) ||
                              (lo_idx == PC_CODE) || (hi_idx == PC_CODE) ||
                              (lo_idx == hi_idx));

endmodule

// File: rtl/lmac_datapath.sv
module lmac_datapath
   import lmac_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  lmac_ctl_t         ctl,
   input  logic [XLEN-1:0]   rn,
   input  logic [XLEN-1:0]   rm,
   input  logic [XLEN-1:0]   acc_lo,
   input  logic [XLEN-1:0]   acc_hi,
   output logic [2*XLEN-1:0] res
);

   localparam int HALF = XLEN / 2;
   localparam int WIDE = 2 * XLEN;

   logic [HALF-1:0] n_lo, n_hi, m_lo, m_hi;
   logic [WIDE-1:0] lane_ext [2];
   logic [WIDE-1:0] acc, ext_n, ext_m, wide_prod;
   logic [WIDE:0]   dbl_sum;

   assign n_lo = rn[HALF-1:0];
   assign n_hi = rn[XLEN-1:HALF];
   assign m_lo = rm[HALF-1:0];
   assign m_hi = rm[XLEN-1:HALF];
   assign acc  = {acc_hi, acc_lo};

   // Two signed halfword lanes; lane 0 also serves the single halfword form.
   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [HALF-1:0]        a, b;
      logic signed [XLEN-1:0] p;
      if (g == 0) begin : g_sel0
         assign a = (ctl.op == OP_HALF && ctl.n_sel) ? n_hi : n_lo;
         assign b = ctl.m_sel ? m_hi : m_lo;
      end else begin : g_sel1
         assign a = n_hi;
         assign b = ctl.m_sel ? m_lo : m_hi;
      end
      assign p           = $signed(a) * $signed(b);
      assign lane_ext[g] = {{XLEN{p[XLEN-1]}}, p};
   end

   // One full-width multiplier, sign handling by the extension bits.
   assign ext_n     = {{XLEN{ctl.sgn & rn[XLEN-1]}}, rn};
   assign ext_m     = {{XLEN{ctl.sgn & rm[XLEN-1]}}, rm};
   assign wide_prod = ext_n * ext_m;
   assign dbl_sum   = {1'b0, wide_prod} + {{(XLEN+1){1'b0}}, acc_hi}
                                        + {{(XLEN+1){1'b0}}, acc_lo};

   always_comb begin
      case (ctl.op)
         OP_MULL:  res = wide_prod;
         OP_MLAL:  res = wide_prod + acc;
         OP_HALF:  res = lane_ext[0] + acc;
         OP_DUAL:  res = ctl.sub ? lane_ext[0] - lane_ext[1] + acc
                                 : lane_ext[0] + lane_ext[1] + acc;
         OP_UMAAL: res = dbl_sum[WIDE-1:0];
         default:  res = '0;
      endcase
   end

   // R7
   always_comb begin
      if (ctl.op == OP_UMAAL)
         umaal_no_overflow_chk: assert (dbl_sum[WIDE] == 1'b0)
            else $error("double accumulate carried out of the result width");
   end

endmodule

// File: rtl/lmac_unit.sv
module lmac_unit
   import lmac_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int IDX_W  = 4,
   parameter int PC_IDX = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [31:0]      insn,
   input  logic [XLEN-1:0]  rn_val,
   input  logic [XLEN-1:0]  rm_val,
   input  logic [XLEN-1:0]  acc_lo_val,
   input  logic [XLEN-1:0]  acc_hi_val,
   output logic [XLEN-1:0]  res_lo_o,
   output logic [XLEN-1:0]  res_hi_o,
   output logic [IDX_W-1:0] lo_idx_o,
   output logic [IDX_W-1:0] hi_idx_o,
   output logic             lo_we_o,
   output logic             hi_we_o,
   output logic             undef_o,
   output logic             unpred_o
);

   localparam int WIDE = 2 * XLEN;

   if (XLEN % 2 != 0 || XLEN < 4) begin : g_bad_xlen
      $error("XLEN must be even and at least 4");
   end
   if (IDX_W < 4 || PC_IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("IDX_W must hold the 4-bit fields and PC_IDX");
   end

   lmac_ctl_t        ctl;
   logic             dec_undef, dec_unpred;
   logic [IDX_W-1:0] dec_lo, dec_hi;
   logic [WIDE-1:0]  result;
   logic             legal;

   lmac_decode #(.IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_decode (
      .insn   (insn),
      .ctl    (ctl),
      .undef  (dec_undef),
      .unpred (dec_unpred),
      .lo_idx (dec_lo),
      .hi_idx (dec_hi)
   );

   lmac_datapath #(.XLEN(XLEN)) u_datapath (
      .ctl    (ctl),
      .rn     (rn_val),
      .rm     (rm_val),
      .acc_lo (acc_lo_val),
      .acc_hi (acc_hi_val),
      .res    (result)
   );

   assign legal = in_valid && !dec_undef && !dec_unpred;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_lo_o <= '0;
         res_hi_o <= '0;
         lo_idx_o <= '0;
         hi_idx_o <= '0;
         lo_we_o  <= 1'b0;
         hi_we_o  <= 1'b0;
         undef_o  <= 1'b0;
         unpred_o <= 1'b0;
      end else begin
         lo_we_o  <= legal;
         hi_we_o  <= legal;
         undef_o  <= in_valid && dec_undef;
         unpred_o <= in_valid && dec_unpred;
         if (in_valid) begin
            res_lo_o <= result[XLEN-1:0];
            res_hi_o <= result[WIDE-1:XLEN];
            lo_idx_o <= dec_lo;
            hi_idx_o <= dec_hi;
         end
      end
   end

   // R8
   legal_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we_o |-> (lo_idx_o != IDX_W'(PC_IDX)) && (hi_idx_o != IDX_W'(PC_IDX)) &&
                  (lo_idx_o != hi_idx_o));

   // R9
   undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      undef_o |-> !lo_we_o && !hi_we_o && !unpred_o);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> !lo_we_o && !undef_o && !unpred_o);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> $stable(res_lo_o) && $stable(res_hi_o));

   // R10
   we_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lo_we_o, undef_o, unpred_o}) && (lo_we_o == hi_we_o));

endmodule

// File: tb/lmac_unit_bench.sv
module lmac_unit_bench;

   localparam int XLEN = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] insn = '0, rn_val = '0, rm_val = '0, acc_lo_val = '0, acc_hi_val = '0;
   logic [31:0] res_lo_o, res_hi_o;
   logic [3:0]  lo_idx_o, hi_idx_o;
   logic        lo_we_o, hi_we_o, undef_o, unpred_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   lmac_unit #(.XLEN(XLEN), .IDX_W(4), .PC_IDX(15)) u_lmac_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
      .rn_val(rn_val), .rm_val(rm_val), .acc_lo_val(acc_lo_val), .acc_hi_val(acc_hi_val),
      .res_lo_o(res_lo_o), .res_hi_o(res_hi_o), .lo_idx_o(lo_idx_o), .hi_idx_o(hi_idx_o),
      .lo_we_o(lo_we_o), .hi_we_o(hi_we_o), .undef_o(undef_o), .unpred_o(unpred_o)
   );

   function automatic logic [31:0] mk(input logic [3:0] p, n, dl, dh, f, m);
      return {8'hFB, p, n, dl, dh, f, m};
   endfunction

   typedef struct packed {
      logic [23:0] tag;
      logic [31:0] w, rn, rm, lo, hi;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{"R3 ", mk(4'h8,4'd1,4'd2,4'd3,4'h0,4'd4), 32'hFFFFFFFF, 32'h00000002, 32'h11111111, 32'h22222222},
      '{"R3 ", mk(4'h8,4'd0,4'd6,4'd7,4'h0,4'd1), 32'h80000000, 32'h80000000, 32'h0, 32'h0},
      '{"R3 ", mk(4'hA,4'd3,4'd4,4'd5,4'h0,4'd6), 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h1, 32'h2},
      '{"R4 ", mk(4'hC,4'd1,4'd2,4'd3,4'h0,4'd4), 32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000001},
      '{"R4 ", mk(4'hE,4'd8,4'd9,4'd10,4'h0,4'd11), 32'hFFFFFFFF, 32'h00010000, 32'hFFFFFFFF, 32'hFFFFFFFF},
      '{"R5 ", mk(4'hC,4'd1,4'd2,4'd3,4'h8,4'd4), 32'h1234FFFE, 32'h7FFF0003, 32'h00000010, 32'h0},
      '{"R5 ", mk(4'hC,4'd1,4'd2,4'd3,4'hB,4'd4), 32'h80000001, 32'h80000002, 32'h0, 32'h80000000},
      '{"R5 ", mk(4'hC,4'd5,4'd2,4'd3,4'hA,4'd4), 32'hFFFF0005, 32'h00058000, 32'h5, 32'h0},
      '{"R6 ", mk(4'hC,4'd1,4'd2,4'd3,4'hC,4'd4), 32'h80008000, 32'h80008000, 32'h0, 32'h0},
      '{"R6 ", mk(4'hC,4'd1,4'd2,4'd3,4'hD,4'd4), 32'h00030002, 32'h00070005, 32'h100, 32'h0},
      '{"R6 ", mk(4'hD,4'd1,4'd2,4'd3,4'hC,4'd4), 32'h00010000, 32'h80000000, 32'h0, 32'h0},
      '{"R6 ", mk(4'hD,4'd1,4'd2,4'd3,4'hD,4'd4), 32'hFFFE0003, 32'h00047FFF, 32'h0, 32'hFFFFFFFF},
      '{"R7 ", mk(4'hE,4'd1,4'd2,4'd3,4'h6,4'd4), 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
      '{"R8 ", mk(4'h8,4'd15,4'd2,4'd3,4'h0,4'd4), 32'h5, 32'h6, 32'h0, 32'h0},
      '{"R8 ", mk(4'hA,4'd1,4'd5,4'd5,4'h0,4'd2), 32'h5, 32'h6, 32'h0, 32'h0},
      '{"R8 ", mk(4'hE,4'd1,4'd2,4'd3,4'h6,4'd15), 32'h5, 32'h6, 32'h0, 32'h0},
      '{"R9 ", mk(4'h8,4'd1,4'd2,4'd3,4'h1,4'd4), 32'h5, 32'h6, 32'h0, 32'h0},
      '{"R9 ", mk(4'hD,4'd1,4'd2,4'd3,4'h0,4'd4), 32'h5, 32'h6, 32'h0, 32'h0},
      '{"R9 ", mk(4'h9,4'd1,4'd15,4'd3,4'hF,4'd4), 32'h5, 32'h6, 32'h0, 32'h0},
      '{"R9 ", mk(4'hE,4'd1,4'd2,4'd3,4'h8,4'd4), 32'h5, 32'h6, 32'h0, 32'h0},
      '{"R9 ", 32'h00000000, 32'h5, 32'h6, 32'h0, 32'h0}
   };

   // Behavioural 64-bit reference built from the requirements.
   function automatic void ref_op(input logic [31:0] w, rn, rm, lo, hi,
                                  output logic [63:0] r, output logic ud, output logic up);
      logic [3:0] p, f;
      longint sn, sm, un, um, acc, nl, nh, ml, mh, b0, b1, a;
      p   = w[23:20];
      f   = w[7:4];
      sn  = {{32{rn[31]}}, rn};
      sm  = {{32{rm[31]}}, rm};
      un  = {32'h0, rn};
      um  = {32'h0, rm};
      acc = {hi, lo};
      nl  = {{48{rn[15]}}, rn[15:0]};
      nh  = {{48{rn[31]}}, rn[31:16]};
      ml  = {{48{rm[15]}}, rm[15:0]};
      mh  = {{48{rm[31]}}, rm[31:16]};
      r   = '0;
      ud  = 1'b1;
      if (w[31:24] == 8'hFB) begin
         if (p == 4'h8 && f == 4'h0) begin r = sn * sm; ud = 0; end
         else if (p == 4'hA && f == 4'h0) begin r = un * um; ud = 0; end
         else if (p == 4'hC && f == 4'h0) begin r = sn * sm + acc; ud = 0; end
         else if (p == 4'hE && f == 4'h0) begin r = un * um + acc; ud = 0; end
         else if (p == 4'hE && f == 4'h6) begin r = un * um + {32'h0, hi} + {32'h0, lo}; ud = 0; end
         else if (p == 4'hC && f[3:2] == 2'b10) begin
            a  = f[1] ? nh : nl;
            b0 = f[0] ? mh : ml;
            r  = a * b0 + acc; ud = 0;
         end else if ((p == 4'hC || p == 4'hD) && f[3:1] == 3'b110) begin
            b0 = f[0] ? mh : ml;
            b1 = f[0] ? ml : mh;
            r  = (p == 4'hD) ? nl * b0 - nh * b1 + acc : nl * b0 + nh * b1 + acc;
            ud = 0;
         end
      end
      up = !ud && (w[19:16] == 4'd15 || w[15:12] == 4'd15 || w[11:8] == 4'd15 ||
                   w[3:0] == 4'd15 || w[15:12] == w[11:8]);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [63:0] er;
      logic eud, eup;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk({lo_we_o, hi_we_o, undef_o, unpred_o} == 4'b0, "R1 reset flags",
          {60'h0, lo_we_o, hi_we_o, undef_o, unpred_o}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({lo_we_o, hi_we_o, undef_o, unpred_o} == 4'b0, "R1 after release",
          {60'h0, lo_we_o, hi_we_o, undef_o, unpred_o}, 64'h0);

      // Table walk, one vector per cycle
      for (int i = 0; i < NV; i++) begin
         insn = VECS[i].w; rn_val = VECS[i].rn; rm_val = VECS[i].rm;
         acc_lo_val = VECS[i].lo; acc_hi_val = VECS[i].hi;
         in_valid = 1'b1;
         @(negedge clk);
         ref_op(VECS[i].w, VECS[i].rn, VECS[i].rm, VECS[i].lo, VECS[i].hi, er, eud, eup);
         chk(undef_o == eud && unpred_o == eup,
             $sformatf("%s flags vec %0d", VECS[i].tag, i),
             {62'h0, undef_o, unpred_o}, {62'h0, eud, eup});
         chk(lo_we_o == !(eud || eup) && hi_we_o == !(eud || eup),
             $sformatf("%s write enable vec %0d", VECS[i].tag, i),
             {62'h0, lo_we_o, hi_we_o}, {62'h0, !(eud || eup), !(eud || eup)});
         if (!(eud || eup)) begin
            chk({res_hi_o, res_lo_o} == er, $sformatf("%s result vec %0d", VECS[i].tag, i),
                {res_hi_o, res_lo_o}, er);
            // R10: destination indices
            chk(lo_idx_o == VECS[i].w[15:12] && hi_idx_o == VECS[i].w[11:8],
                $sformatf("R10 indices vec %0d", i),
                {56'h0, lo_idx_o, hi_idx_o}, {56'h0, VECS[i].w[15:12], VECS[i].w[11:8]});
         end
      end

      // R2: a legal op, then an idle cycle with different operands
      insn = mk(4'hA, 4'd1, 4'd2, 4'd3, 4'h0, 4'd4);
      rn_val = 32'd7; rm_val = 32'd9;
      @(negedge clk);
      chk({res_hi_o, res_lo_o} == 64'd63 && lo_we_o, "R2 one-cycle latency",
          {res_hi_o, res_lo_o}, 64'd63);
      in_valid = 1'b0;
      rn_val = 32'd100;
      insn = mk(4'h8, 4'd1, 4'd2, 4'd2, 4'h1, 4'd4);
      @(negedge clk);
      chk({lo_we_o, hi_we_o, undef_o, unpred_o} == 4'b0, "R2 idle quiet",
          {60'h0, lo_we_o, hi_we_o, undef_o, unpred_o}, 64'h0);
      chk({res_hi_o, res_lo_o} == 64'd63, "R2 idle hold", {res_hi_o, res_lo_o}, 64'd63);

      finish_run();
   end

endmodule